// File: doc/BRIEF.md
# Multi-Hart Prescaled Step Timer

This block keeps one free-running 64-bit time base per hart and a bank of 64-bit compare registers beside each one. A hart's counter moves only while its bit in a shared run-control register is set. A per-hart prescaler counts clock cycles and, once every (prescale + 1) cycles, adds a programmable step to the counter. The effective tick rate is therefore the clock rate times step divided by (prescale + 1). For example, a 50 MHz clock with prescale 4 and step 12 gives 120 MHz, and prescale 49 with step 1 gives 1 MHz.

Software reaches everything through a simple word-wide register port. Reads return their data one cycle after the request. Address 0x000 holds the run-control register. Hart h owns a 0x100-byte window that starts at 0x100 × (h + 1). Inside a window the layout is as follows:

- 0x00: configuration word.
- 0x08 and 0x0C: counter lower and upper halves.
- 0x10: interrupt enable.
- 0x14: interrupt status.
- 0x18: interrupt force.
- 0x20 + 8c: compare register c, with its lower word first and its upper word at +4.

Every compare register drives a sticky status bit. Each status bit, masked by its enable bit, drives one interrupt line.

Top module: `mh_step_timer`

## Requirements
- R1: Out of reset the following values hold:
  - run-control reads 0;
  - every counter reads 0;
  - every compare half reads 0xFFFFFFFF;
  - the configuration word reads 0x00010000 (prescale 0, step 1);
  - enable and status read 0;
  - all interrupt lines are low.
- R2: While bit h of run-control is 0, the counter of hart h holds its value unless software writes it.
- R3: The configuration word carries prescale in bits 11:0 and step in bits 23:16. While hart h is enabled, its counter gains step once every (prescale + 1) clock cycles.
- R4: The counter halves at window offsets 0x08 (bits 31:0) and 0x0C (bits 63:32) can each be written and read back independently.
- R5: A status bit becomes 1 on the clock after the counter is greater than or equal to the 64-bit compare value, including the case where the two are equal. It stays 0 while the counter is below the compare value.
- R6: Writing the status word (0x14) clears each bit written as 1 and leaves every bit written as 0 unchanged.
- R7: Writing 1 to bit c of the force word (0x18) sets status bit c. The force word itself reads as 0.
- R8: Interrupt line h × NUM_CMP + c equals status bit c of hart h ANDed with enable bit c (0x10) of hart h.
- R9: The following reads return 0, and writes to them change nothing:
  - offsets with no register;
  - misaligned offsets;
  - windows above the last hart.
- R10: Clearing a hart's run bit restarts its prescaler. After the bit is set again, the first step arrives after a full prescale + 1 cycles.
- R11: Each hart's counter, configuration and run bit act only on that hart. Writing or running one hart leaves the others unchanged.
- R12: A read request is answered by bus_rvalid high, with bus_rdata, exactly one cycle later. bus_rvalid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request, one cycle per word |
| bus_rd | input | 1 | Read request, one cycle per word |
| bus_addr | input | ADDR_W (12) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after bus_rd |
| irq_o | output | NUM_HARTS*NUM_CMP (4) | Interrupt lines, hart-major |

## Verification
The bench first targets the prescaler:
- It runs the counter for exact cycle counts with prescale 3 and step 5. A prescaler that is off by one, or that ignores the step, gives a count other than 25.
- It then toggles the run bit mid-period. A prescaler that keeps its partial count across a disable adds an extra step.

For the compare logic, the bench moves the counter to exactly the compare value and to one below it. A design that uses a strict greater-than comparison, or checks only the lower word, misses the equality case or fires early.

For the status and force registers, the bench writes zeros, single bits and force pulses. A status register that is write-to-set, fully cleared by any write, or left unmasked on the interrupt lines gives wrong read-back values or wrong interrupt levels.

Finally, the bench probes unmapped and out-of-range windows and a second hart. This catches aliasing and cross-hart leakage.

// File: rtl/mst_pkg.sv
package mst_pkg;
    localparam int CNT_W     = 64;
    localparam int WORD_W    = 32;
    localparam int PRE_W     = 12;
    localparam int STEP_W    = 8;
    localparam int WIN_SHIFT = 8;
    localparam int CMP_IDX_W = 5;
    localparam int STEP_LSB  = 16;

    localparam logic [WIN_SHIFT-1:0] OFF_CTRL     = 8'h00;
    localparam logic [WIN_SHIFT-1:0] OFF_CFG      = 8'h00;
    localparam logic [WIN_SHIFT-1:0] OFF_CNT_LO   = 8'h08;
    localparam logic [WIN_SHIFT-1:0] OFF_CNT_HI   = 8'h0C;
    localparam logic [WIN_SHIFT-1:0] OFF_IEN      = 8'h10;
    localparam logic [WIN_SHIFT-1:0] OFF_IST      = 8'h14;
    localparam logic [WIN_SHIFT-1:0] OFF_ITEST    = 8'h18;
    localparam logic [WIN_SHIFT-1:0] OFF_CMP_BASE = 8'h20;

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [PRE_W-1:0]  pre;
    } tick_cfg_t;

    localparam tick_cfg_t CFG_RESET = '{step: STEP_W'(1), pre: '0};

    // One-hot view of which window field an offset selects
    typedef struct packed {
        logic                 cfg;
        logic                 cnt_lo;
        logic                 cnt_hi;
        logic                 ien;
        logic                 ist;
        logic                 itest;
        logic                 cmp_lo;
        logic                 cmp_hi;
        logic [CMP_IDX_W-1:0] idx;
    } field_t;

    function automatic logic [WORD_W-1:0] cfg_to_word(input tick_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[PRE_W-1:0] = c.pre;
        w[STEP_LSB +: STEP_W] = c.step;
        return w;
    endfunction

    function automatic tick_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        tick_cfg_t c;
        c.pre  = w[PRE_W-1:0];
        c.step = w[STEP_LSB +: STEP_W];
        return c;
    endfunction

    function automatic field_t decode_offset(input logic [WIN_SHIFT-1:0] off, input int ncmp);
        field_t f;
        logic [WIN_SHIFT-1:0] rel;
        f   = '0;
        rel = off - OFF_CMP_BASE;
        case (off)
            OFF_CFG:    f.cfg    = 1'b1;
            OFF_CNT_LO: f.cnt_lo = 1'b1;
            OFF_CNT_HI: f.cnt_hi = 1'b1;
            OFF_IEN:    f.ien    = 1'b1;
            OFF_IST:    f.ist    = 1'b1;
            OFF_ITEST:  f.itest  = 1'b1;
            default: begin
                if (off[1:0] == 2'b00 && off >= OFF_CMP_BASE &&
                    int'(rel[WIN_SHIFT-1:3]) < ncmp) begin
                    f.idx    = CMP_IDX_W'(rel[WIN_SHIFT-1:3]);
                    f.cmp_lo = ~rel[2];
                    f.cmp_hi = rel[2];
                end
            end
        endcase
        return f;
    endfunction
endpackage

// File: rtl/mst_tick.sv
module mst_tick
    import mst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              cfg_we,
    input  logic              cnt_lo_we,
    input  logic              cnt_hi_we,
    input  logic [WORD_W-1:0] wdata,
    output tick_cfg_t         cfg_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [PRE_W-1:0]  pc_q
);
    logic tick;

    assign tick = en && (pc_q == cfg_q.pre);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (cfg_we) begin
            cfg_q <= word_to_cfg(wdata);
        end
    end

    // Prescaler: restarts whenever the hart is stopped
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pc_q <= '0;
        end else if (pc_q >= cfg_q.pre) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + PRE_W'(1);
        end
    end

    // Software writes win over a step in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_lo_we || cnt_hi_we) begin
            if (cnt_lo_we) cnt_q[WORD_W-1:0]     <= wdata;
            if (cnt_hi_we) cnt_q[CNT_W-1:WORD_W] <= wdata;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(cfg_q.step);
        end
    end
endmodule

// File: rtl/mst_cmp_bank.sv
module mst_cmp_bank
    import mst_pkg::*;
#(
    parameter int NUM_CMP = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [CNT_W-1:0]                 cnt,
    input  logic [WORD_W-1:0]                wdata,
    input  logic                             cmp_lo_we,
    input  logic                             cmp_hi_we,
    input  logic [CMP_IDX_W-1:0]             cmp_idx,
    input  logic                             ien_we,
    input  logic                             ist_we,
    input  logic                             itest_we,
    output logic [NUM_CMP-1:0][CNT_W-1:0]    cmp_q,
    output logic [NUM_CMP-1:0]               ien_q,
    output logic [NUM_CMP-1:0]               ist_q,
    output logic [NUM_CMP-1:0]               irq
);
    logic [NUM_CMP-1:0] hit;
    logic [NUM_CMP-1:0] clr_v;
    logic [NUM_CMP-1:0] set_v;

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        logic [CNT_W-1:0] val_q;
        logic             sel;

        assign sel = (cmp_idx == CMP_IDX_W'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '1;
            end else begin
                if (cmp_lo_we && sel) val_q[WORD_W-1:0]     <= wdata;
                if (cmp_hi_we && sel) val_q[CNT_W-1:WORD_W] <= wdata;
            end
        end

        assign cmp_q[c] = val_q;
        assign hit[c]   = (cnt >= val_q);
    end

    assign clr_v = ist_we   ? wdata[NUM_CMP-1:0] : '0;
    assign set_v = itest_we ? wdata[NUM_CMP-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= '0;
            ist_q <= '0;
        end else begin
            if (ien_we) ien_q <= wdata[NUM_CMP-1:0];
            ist_q <= (ist_q & ~clr_v) | hit | set_v;
        end
    end

    assign irq = ist_q & ien_q;
endmodule

// File: rtl/mst_regif.sv
module mst_regif
    import mst_pkg::*;
#(
    parameter int NUM_HARTS = 2,
    parameter int NUM_CMP   = 2,
    parameter int ADDR_W    = 12,
    localparam int WIN_W    = ADDR_W - WIN_SHIFT
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic                                         bus_wr,
    input  logic                                         bus_rd,
    input  logic [ADDR_W-1:0]                            bus_addr,
    input  logic [NUM_HARTS-1:0]                         ctrl_wdata,
    input  tick_cfg_t [NUM_HARTS-1:0]                    cfg_all,
    input  logic [NUM_HARTS-1:0][CNT_W-1:0]              cnt_all,
    input  logic [NUM_HARTS-1:0][NUM_CMP-1:0]            ien_all,
    input  logic [NUM_HARTS-1:0][NUM_CMP-1:0]            ist_all,
    input  logic [NUM_HARTS-1:0][NUM_CMP-1:0][CNT_W-1:0] cmp_all,
    output logic [NUM_HARTS-1:0]                         ctrl_q,
    output field_t                                       wr_field,
    output logic [NUM_HARTS-1:0]                         wr_hart,
    output logic [WORD_W-1:0]                            bus_rdata,
    output logic                                         bus_rvalid
);
    logic [WIN_W-1:0]     win;
    logic [WIN_SHIFT-1:0] off;
    field_t               fld;
    logic                 ctrl_hit;
    logic [WORD_W-1:0]    rd_val;

    assign win      = bus_addr[ADDR_W-1:WIN_SHIFT];
    assign off      = bus_addr[WIN_SHIFT-1:0];
    assign fld      = decode_offset(off, NUM_CMP);
    assign ctrl_hit = (win == '0) && (off == OFF_CTRL);
    assign wr_field = fld;

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_sel
        assign wr_hart[h] = bus_wr && (win == WIN_W'(h + 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (bus_wr && ctrl_hit) begin
            ctrl_q <= ctrl_wdata;
        end
    end

    always_comb begin
        rd_val = '0;
        if (ctrl_hit) rd_val = WORD_W'(ctrl_q);
        for (int h = 0; h < NUM_HARTS; h++) begin
            if (win == WIN_W'(h + 1)) begin
                if (fld.cfg)    rd_val = cfg_to_word(cfg_all[h]);
                if (fld.cnt_lo) rd_val = cnt_all[h][WORD_W-1:0];
                if (fld.cnt_hi) rd_val = cnt_all[h][CNT_W-1:WORD_W];
                if (fld.ien)    rd_val = WORD_W'(ien_all[h]);
                if (fld.ist)    rd_val = WORD_W'(ist_all[h]);
                for (int c = 0; c < NUM_CMP; c++) begin
                    if (fld.idx == CMP_IDX_W'(c)) begin
                        if (fld.cmp_lo) rd_val = cmp_all[h][c][WORD_W-1:0];
                        if (fld.cmp_hi) rd_val = cmp_all[h][c][CNT_W-1:WORD_W];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) bus_rdata <= rd_val;
        end
    end
endmodule

// File: rtl/mh_step_timer.sv
module mh_step_timer
    import mst_pkg::*;
#(
    parameter int NUM_HARTS = 2,
    parameter int NUM_CMP   = 2,
    parameter int ADDR_W    = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [WORD_W-1:0]            bus_wdata,
    output logic [WORD_W-1:0]            bus_rdata,
    output logic                         bus_rvalid,
    output logic [NUM_HARTS*NUM_CMP-1:0] irq_o
);
    logic [NUM_HARTS-1:0]                         ctrl_q;
    field_t                                       wr_field;
    logic [NUM_HARTS-1:0]                         wr_hart;
    tick_cfg_t [NUM_HARTS-1:0]                    cfg_all;
    logic [NUM_HARTS-1:0][CNT_W-1:0]              cnt_all;
    logic [NUM_HARTS-1:0][PRE_W-1:0]              pc_all;
    logic [NUM_HARTS-1:0][NUM_CMP-1:0]            ien_all;
    logic [NUM_HARTS-1:0][NUM_CMP-1:0]            ist_all;
    logic [NUM_HARTS-1:0][NUM_CMP-1:0][CNT_W-1:0] cmp_all;

    mst_regif #(
        .NUM_HARTS(NUM_HARTS),
        .NUM_CMP  (NUM_CMP),
        .ADDR_W   (ADDR_W)
    ) u_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .ctrl_wdata(bus_wdata[NUM_HARTS-1:0]),
        .cfg_all   (cfg_all),
        .cnt_all   (cnt_all),
        .ien_all   (ien_all),
        .ist_all   (ist_all),
        .cmp_all   (cmp_all),
        .ctrl_q    (ctrl_q),
        .wr_field  (wr_field),
        .wr_hart   (wr_hart),
        .bus_rdata (bus_rdata),
        .bus_rvalid(bus_rvalid)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        logic [NUM_CMP-1:0] irq_h;

        mst_tick u_tick (
            .clk      (clk),
            .rst      (rst),
            .en       (ctrl_q[h]),
            .cfg_we   (wr_hart[h] && wr_field.cfg),
            .cnt_lo_we(wr_hart[h] && wr_field.cnt_lo),
            .cnt_hi_we(wr_hart[h] && wr_field.cnt_hi),
            .wdata    (bus_wdata),
            .cfg_q    (cfg_all[h]),
            .cnt_q    (cnt_all[h]),
            .pc_q     (pc_all[h])
        );

        mst_cmp_bank #(
            .NUM_CMP(NUM_CMP)
        ) u_cmp (
            .clk      (clk),
            .rst      (rst),
            .cnt      (cnt_all[h]),
            .wdata    (bus_wdata),
            .cmp_lo_we(wr_hart[h] && wr_field.cmp_lo),
            .cmp_hi_we(wr_hart[h] && wr_field.cmp_hi),
            .cmp_idx  (wr_field.idx),
            .ien_we   (wr_hart[h] && wr_field.ien),
            .ist_we   (wr_hart[h] && wr_field.ist),
            .itest_we (wr_hart[h] && wr_field.itest),
            .cmp_q    (cmp_all[h]),
            .ien_q    (ien_all[h]),
            .ist_q    (ist_all[h]),
            .irq      (irq_h)
        );

        assign irq_o[h*NUM_CMP +: NUM_CMP] = irq_h;
    end
endmodule

// File: rtl/mst_chk.sv
module mst_chk
    import mst_pkg::*;
#(
    parameter int NUM_HARTS = 2,
    parameter int NUM_CMP   = 2,
    parameter int ADDR_W    = 12,
    localparam int WIN_W    = ADDR_W - WIN_SHIFT
) (
    input logic                                         clk,
    input logic                                         rst,
    input logic                                         bus_wr,
    input logic                                         bus_rd,
    input logic [ADDR_W-1:0]                            bus_addr,
    input logic [WORD_W-1:0]                            bus_wdata,
    input logic [WORD_W-1:0]                            bus_rdata,
    input logic                                         bus_rvalid,
    input logic [NUM_HARTS*NUM_CMP-1:0]                 irq_o,
    input logic [NUM_HARTS-1:0]                         ctrl_q,
    input tick_cfg_t [NUM_HARTS-1:0]                    cfg_all,
    input logic [NUM_HARTS-1:0][CNT_W-1:0]              cnt_all,
    input logic [NUM_HARTS-1:0][PRE_W-1:0]              pc_all,
    input logic [NUM_HARTS-1:0][NUM_CMP-1:0]            ist_all,
    input logic [NUM_HARTS-1:0][NUM_CMP-1:0][CNT_W-1:0] cmp_all
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq_o == '0));

    // R12
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);

    // R12
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !bus_rvalid);

    // R9
    empty_window_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (int'(bus_addr[ADDR_W-1:WIN_SHIFT]) > NUM_HARTS)) |=> (bus_rdata == '0));

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_h
        // R2
        frozen_count_chk: assert property (@(posedge clk) disable iff (rst)
            (!ctrl_q[h] && !bus_wr) |=> $stable(cnt_all[h]));

        // R3
        step_add_chk: assert property (@(posedge clk) disable iff (rst)
            (ctrl_q[h] && !bus_wr && (pc_all[h] == cfg_all[h].pre))
            |=> (cnt_all[h] == $past(cnt_all[h]) + CNT_W'($past(cfg_all[h].step))));

        for (genvar c = 0; c < NUM_CMP; c++) begin : g_c
            // R5
            compare_set_chk: assert property (@(posedge clk) disable iff (rst)
                (cnt_all[h] >= cmp_all[h][c]) |=> ist_all[h][c]);

            // R7
            force_set_chk: assert property (@(posedge clk) disable iff (rst)
                (bus_wr && (bus_addr == {WIN_W'(h + 1), OFF_ITEST}) && bus_wdata[c])
                |=> ist_all[h][c]);
        end
    end
endmodule

bind mh_step_timer mst_chk #(
    .NUM_HARTS(NUM_HARTS),
    .NUM_CMP  (NUM_CMP),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid),
    .irq_o     (irq_o),
    .ctrl_q    (ctrl_q),
    .cfg_all   (cfg_all),
    .cnt_all   (cnt_all),
    .pc_all    (pc_all),
    .ist_all   (ist_all),
    .cmp_all   (cmp_all)
);

// File: tb/mh_step_timer_test.sv
module mh_step_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [3:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    mh_step_timer uut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rvalid(bus_rvalid),
        .irq_o     (irq_o)
    );

    localparam logic [11:0] H0 = 12'h100;
    localparam logic [11:0] H1 = 12'h200;

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: queues the expected word, the monitor compares it
    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, e);
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R12 unexpected rvalid actual=%h expected=none", bus_rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(32'(irq_o), 32'h0, "R1 irq after reset");
        rd(12'h000, 32'h0, "R1 ctrl reset");
        rd(H0 + 12'h00, 32'h0001_0000, "R1 cfg reset");
        rd(H0 + 12'h08, 32'h0, "R1 cnt lo reset");
        rd(H0 + 12'h0C, 32'h0, "R1 cnt hi reset");
        rd(H0 + 12'h20, 32'hFFFF_FFFF, "R1 cmp0 lo reset");
        rd(H0 + 12'h2C, 32'hFFFF_FFFF, "R1 cmp1 hi reset");
        rd(H0 + 12'h10, 32'h0, "R1 ien reset");
        rd(H0 + 12'h14, 32'h0, "R1 ist reset");

        // R2 / R4 disabled counter holds, halves independent
        repeat (10) @(negedge clk);
        rd(H0 + 12'h08, 32'h0, "R2 idle counter");
        wr(H0 + 12'h08, 32'h5);
        wr(H0 + 12'h0C, 32'h7);
        repeat (8) @(negedge clk);
        rd(H0 + 12'h08, 32'h5, "R4 cnt lo");
        rd(H0 + 12'h0C, 32'h7, "R4 cnt hi R2 held");

        // R3 prescale 3, step 5, 20 enabled cycles -> 5 steps
        wr(H0 + 12'h08, 32'h0);
        wr(H0 + 12'h0C, 32'h0);
        wr(H0 + 12'h00, 32'h0005_0003);
        rd(H0 + 12'h00, 32'h0005_0003, "R3 cfg readback");
        wr(12'h000, 32'h1);
        repeat (19) @(negedge clk);
        wr(12'h000, 32'h0);
        rd(H0 + 12'h08, 32'd25, "R3 stepped count");
        rd(H0 + 12'h0C, 32'h0, "R3 upper half");
        rd(H1 + 12'h08, 32'h0, "R11 other hart idle");

        // R10 partial period, stop, restart: no step
        wr(12'h000, 32'h1);
        repeat (1) @(negedge clk);
        wr(12'h000, 32'h0);
        repeat (2) @(negedge clk);
        wr(12'h000, 32'h1);
        repeat (1) @(negedge clk);
        wr(12'h000, 32'h0);
        rd(H0 + 12'h08, 32'd25, "R10 prescaler restart");

        // R5 compare, including equality
        wr(H0 + 12'h00, 32'h0001_0000);
        wr(H0 + 12'h08, 32'h0);
        wr(H0 + 12'h20, 32'd10);
        wr(H0 + 12'h24, 32'h0);
        wr(H0 + 12'h10, 32'h1);
        rd(H0 + 12'h14, 32'h0, "R5 below compare");
        wr(12'h000, 32'h1);
        repeat (4) @(negedge clk);
        wr(12'h000, 32'h0);
        rd(H0 + 12'h08, 32'd5, "R3 step one");
        rd(H0 + 12'h14, 32'h0, "R5 count 5 < 10");
        chk(32'(irq_o), 32'h0, "R8 no irq yet");
        wr(12'h000, 32'h1);
        repeat (9) @(negedge clk);
        wr(12'h000, 32'h0);
        rd(H0 + 12'h08, 32'd15, "R3 count 15");
        rd(H0 + 12'h14, 32'h1, "R5 reached compare");
        chk(32'(irq_o), 32'h1, "R8 irq0 enabled");
        wr(H0 + 12'h2C, 32'h0);
        wr(H0 + 12'h28, 32'd16);
        rd(H0 + 12'h14, 32'h1, "R5 one below compare");
        wr(H0 + 12'h28, 32'd15);
        rd(H0 + 12'h14, 32'h3, "R5 equal compare");

        // R6 write-one-to-clear
        wr(H0 + 12'h24, 32'hFFFF_FFFF);
        wr(H0 + 12'h2C, 32'hFFFF_FFFF);
        wr(H0 + 12'h14, 32'h0);
        rd(H0 + 12'h14, 32'h3, "R6 zero write no effect");
        wr(H0 + 12'h14, 32'h1);
        rd(H0 + 12'h14, 32'h2, "R6 clear bit0");
        chk(32'(irq_o), 32'h0, "R8 masked bit1");
        wr(H0 + 12'h14, 32'h2);
        rd(H0 + 12'h14, 32'h0, "R6 clear bit1");

        // R7 force
        wr(H0 + 12'h18, 32'h2);
        rd(H0 + 12'h14, 32'h2, "R7 force bit1");
        rd(H0 + 12'h18, 32'h0, "R7 force reads zero");
        chk(32'(irq_o), 32'h0, "R8 force masked");
        wr(H0 + 12'h10, 32'h3);
        chk(32'(irq_o), 32'h2, "R8 force enabled");

        // R11 second hart
        wr(H1 + 12'h08, 32'hDEAD_BEEF);
        wr(H1 + 12'h0C, 32'hCAFE_FEED);
        rd(H1 + 12'h08, 32'hDEAD_BEEF, "R11 hart1 lo");
        rd(H1 + 12'h0C, 32'hCAFE_FEED, "R11 hart1 hi");
        rd(H0 + 12'h08, 32'd15, "R11 hart0 untouched");
        wr(12'h000, 32'h2);
        repeat (2) @(negedge clk);
        wr(12'h000, 32'h0);
        rd(H1 + 12'h08, 32'hDEAD_BEF2, "R11 hart1 ran");
        rd(H0 + 12'h08, 32'd15, "R11 hart0 held");
        rd(12'h000, 32'h0, "R11 ctrl cleared");

        // R9 unmapped
        rd(12'h0F0, 32'h0, "R9 global hole");
        rd(H0 + 12'hFC, 32'h0, "R9 window hole");
        rd(H0 + 12'h09, 32'h0, "R9 misaligned");
        rd(12'h300, 32'h0, "R9 absent hart");
        wr(12'h308, 32'hFFFF_FFFF);
        wr(H0 + 12'hFC, 32'hFFFF_FFFF);
        wr(H0 + 12'h0A, 32'hFFFF_FFFF);
        rd(H0 + 12'h08, 32'd15, "R9 write ignored h0");
        rd(H1 + 12'h08, 32'hDEAD_BEF2, "R9 write ignored h1");
        rd(H0 + 12'hFC, 32'h0, "R9 hole stays zero");
        chk(32'(irq_o), 32'h2, "R9 irq unchanged");

        // R12 no valid without request
        @(negedge clk);
        @(negedge clk);
        chk(32'(bus_rvalid), 32'h0, "R12 idle rvalid");

        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R12 missing responses actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule